// File: doc/BRIEF.md
# Eight-Pin GPIO Expander Register Core

This block is the register core of a small general-purpose I/O expander. A host reaches it through a byte-wide register port with an address, write data, a write strobe, a read strobe and read data. In a complete device, a serial target front end drives that port. The core holds the configuration of each pin: direction, drive level, a driver-disable override, pull enable and pull polarity, interrupt mask and expected input level. It turns that configuration into per-pin output-enable, output-level and pull-control signals for the pad ring.

The pin inputs pass through a synchronizer. The host can read their levels back. Each unmasked pin whose sampled level differs from its programmed expected level sets a sticky status bit, and a read of the status register clears it. An active-low interrupt line is asserted while any status bit is set. It is also asserted while a power-up flag is set. The identification register clears that flag when it is read. A self-clearing software reset bit returns the whole register set to its power-on state.

Top module: `gpx_expander`

## Requirements
- R1: After reset, direction and drive level are 0x00, and the driver-disable, pull-enable, pull-polarity, mask and expected-level registers are all 0xFF. Status is 0x00. With these values `pin_oe` is 0x00 and both `pull_en` and `pull_up` are 0xFF.
- R2: The identification register at address 0x01 reads back in this layout: bits 7:5 are the fixed code 3'b101, bits 4:2 are the `FW_REV` parameter, bit 1 is the power-up flag and bit 0 is always 0. With the default `FW_REV` of 0, it reads 0xA2 after reset.
- R3: A read of address 0x01 clears the power-up flag on that clock edge, so the next read returns 0xA0.
- R4: Direction is at address 0x03 (1 = output) and drive level is at address 0x05. A pin's `pin_oe` bit is 1 when its direction bit is 1 and its disable bit is 0. `pin_out` follows the drive-level register.
- R5: A set bit in the driver-disable register at address 0x07 forces that pin's `pin_oe` bit to 0, whatever its direction.
- R6: The pull-enable register is at address 0x0B and the pull-polarity register is at address 0x0D (1 = up). `pull_en` is asserted only for pins whose direction bit is 0. `pull_up` follows the polarity register.
- R7: Address 0x0F is read-only and returns the pin levels after a two-flop synchronizer. A change on `pin_in` becomes visible there after two rising clock edges.
- R8: The mask register is at address 0x11 (1 = blocked) and the expected-level register is at address 0x09. Each unmasked pin whose synchronized level differs from its expected bit sets its bit of the status register at address 0x13. A masked pin never sets status.
- R9: Status bits stay set until the status register is read, and that read clears them. A bit whose set condition is true during the read stays set after the read.
- R10: `irq_n` is low exactly while any status bit or the power-up flag is set.
- R11: Writing 1 to bit 0 of address 0x01 restores every register to its R1 value and sets the power-up flag again. The bit itself reads back as 0.
- R12: Writes to the read-only addresses 0x0F and 0x13 are ignored, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe; the register updates on the next rising edge |
| reg_rd | input | 1 | Read strobe; triggers the clear-on-read side effects |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_out | output | 8 | Per-pin drive level |
| pull_en | output | 8 | Per-pin pull resistor enable |
| pull_up | output | 8 | Per-pin pull polarity, 1 = up |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check four things on every cycle:
- no status bit rises for a pin that was masked in the previous cycle;
- status bits persist when no read occurs, and clear when a read coincides with no mismatch;
- a software reset disables every driver and raises the interrupt;
- no pin receives a pull and a driver enable at the same time.

Only the bench's scenarios can show the rest. This covers the exact identification layout, the read-clears-flag ordering and the two-edge synchronizer delay. It also covers the case where a persistent mismatch survives a status read, and the fact that writes to read-only addresses leave them untouched.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned ADR_IDC  = 'h01;
   localparam int unsigned ADR_DIR  = 'h03;
   localparam int unsigned ADR_LVL  = 'h05;
   localparam int unsigned ADR_HIZ  = 'h07;
   localparam int unsigned ADR_EXP  = 'h09;
   localparam int unsigned ADR_PEN  = 'h0B;
   localparam int unsigned ADR_PSEL = 'h0D;
   localparam int unsigned ADR_PIN  = 'h0F;
   localparam int unsigned ADR_MASK = 'h11;
   localparam int unsigned ADR_STAT = 'h13;
   localparam logic [2:0]  MFR_CODE = 3'b101;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpx_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= RST_VAL;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  lvl_q,
   output logic [NPINS-1:0]  hiz_q,
   output logic [NPINS-1:0]  exp_q,
   output logic [NPINS-1:0]  pen_q,
   output logic [NPINS-1:0]  psel_q,
   output logic [NPINS-1:0]  mask_q,
   output logic              pwr_flag_q,
   output logic              soft_rst
);
   localparam logic [NPINS-1:0] ONES  = '1;
   localparam logic [NPINS-1:0] ZEROS = '0;

   logic hit_idc;
   assign hit_idc  = (addr == ADDR_W'(ADR_IDC));
   assign soft_rst = wr_en && hit_idc && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= ZEROS; lvl_q <= ZEROS; hiz_q <= ONES; exp_q <= ONES;
         pen_q <= ONES;  psel_q <= ONES; mask_q <= ONES;
      end else if (soft_rst) begin
         dir_q <= ZEROS; lvl_q <= ZEROS; hiz_q <= ONES; exp_q <= ONES;
         pen_q <= ONES;  psel_q <= ONES; mask_q <= ONES;
      end else if (wr_en) begin
         case (addr)
            ADDR_W'(ADR_DIR):  dir_q  <= wdata[NPINS-1:0];
            ADDR_W'(ADR_LVL):  lvl_q  <= wdata[NPINS-1:0];
            ADDR_W'(ADR_HIZ):  hiz_q  <= wdata[NPINS-1:0];
            ADDR_W'(ADR_EXP):  exp_q  <= wdata[NPINS-1:0];
            ADDR_W'(ADR_PEN):  pen_q  <= wdata[NPINS-1:0];
            ADDR_W'(ADR_PSEL): psel_q <= wdata[NPINS-1:0];
            ADDR_W'(ADR_MASK): mask_q <= wdata[NPINS-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pwr_flag_q <= 1'b1;
      else if (soft_rst)          pwr_flag_q <= 1'b1;
      else if (rd_en && hit_idc)  pwr_flag_q <= 1'b0;
   end

   assert_soft_reset_defaults_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dir_q == ZEROS && mask_q == ONES && pwr_flag_q));

   assert_id_read_clears_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit_idc && !soft_rst) |=> !pwr_flag_q);
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins_s,
   input  logic [NPINS-1:0] exp_i,
   input  logic [NPINS-1:0] mask_i,
   input  logic             clr_i,
   input  logic             soft_i,
   output logic [NPINS-1:0] status_q
);
   logic [NPINS-1:0] set_v;

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_bit
         assign set_v[i] = !mask_i[i] && (pins_s[i] != exp_i[i]);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      status_q[i] <= 1'b0;
            else if (soft_i) status_q[i] <= 1'b0;
            else             status_q[i] <= (status_q[i] && !clr_i) || set_v[i];
         end
      end
   endgenerate

   assert_masked_never_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~$past(status_q) & $past(mask_i)) == '0);

   assert_sticky_without_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !soft_i) |=> ((status_q & $past(status_q)) == $past(status_q)));

   assert_read_clears_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_v == '0) |=> (status_q == '0));
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
   import gpx_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [2:0]  FW_REV      = 3'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pull_en,
   output logic [NPINS-1:0]  pull_up,
   output logic              irq_n
);
   generate
      if (NPINS < 1 || NPINS > REG_W) begin : g_bad_pins
         $error("NPINS must lie between 1 and the register width");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NPINS-1:0] dir_q, lvl_q, hiz_q, exp_q, pen_q, psel_q, mask_q;
   logic [NPINS-1:0] pins_s, status_q;
   logic             pwr_flag_q, soft_rst, stat_clr;

   gpx_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .wr_en(reg_wr), .rd_en(reg_rd),
      .dir_q(dir_q), .lvl_q(lvl_q), .hiz_q(hiz_q), .exp_q(exp_q),
      .pen_q(pen_q), .psel_q(psel_q), .mask_q(mask_q),
      .pwr_flag_q(pwr_flag_q), .soft_rst(soft_rst)
   );

   gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s)
   );

   assign stat_clr = reg_rd && (reg_addr == ADDR_W'(ADR_STAT));

   gpx_irq #(.NPINS(NPINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .exp_i(exp_q),
      .mask_i(mask_q), .clr_i(stat_clr), .soft_i(soft_rst),
      .status_q(status_q)
   );

   assign pin_oe  = dir_q & ~hiz_q;
   assign pin_out = lvl_q;
   assign pull_en = pen_q & ~dir_q;
   assign pull_up = psel_q;
   assign irq_n   = !((|status_q) || pwr_flag_q);

   always_comb begin
      case (reg_addr)
         ADDR_W'(ADR_IDC):  reg_rdata = {MFR_CODE, FW_REV, pwr_flag_q, 1'b0};
         ADDR_W'(ADR_DIR):  reg_rdata = REG_W'(dir_q);
         ADDR_W'(ADR_LVL):  reg_rdata = REG_W'(lvl_q);
         ADDR_W'(ADR_HIZ):  reg_rdata = REG_W'(hiz_q);
         ADDR_W'(ADR_EXP):  reg_rdata = REG_W'(exp_q);
         ADDR_W'(ADR_PEN):  reg_rdata = REG_W'(pen_q);
         ADDR_W'(ADR_PSEL): reg_rdata = REG_W'(psel_q);
         ADDR_W'(ADR_PIN):  reg_rdata = REG_W'(pins_s);
         ADDR_W'(ADR_MASK): reg_rdata = REG_W'(mask_q);
         ADDR_W'(ADR_STAT): reg_rdata = REG_W'(status_q);
         default:           reg_rdata = '0;
      endcase
   end

   assert_no_pull_on_driven_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_en & pin_oe) == '0);

   assert_soft_reset_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(ADR_IDC) && reg_wdata[0]) |=> (!irq_n && pin_oe == '0));
endmodule

// File: tb/test_gpx_expander.sv
module test_gpx_expander;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] pin_in = 8'hFF, pin_oe, pin_out, pull_en, pull_up;
   logic       irq_n;
   int         n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   gpx_expander i_gpx_expander (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en), .pull_up(pull_up),
      .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 pull_en", pull_en, 8'hFF);
      chk("R1 pull_up", pull_up, 8'hFF);
      chk("R10 irq_n flag", {7'd0, irq_n}, 8'h00);
      rd(8'h03, v); chk("R1 dir", v, 8'h00);
      rd(8'h11, v); chk("R1 mask", v, 8'hFF);
      rd(8'h07, v); chk("R1 hiz", v, 8'hFF);
      rd(8'h13, v); chk("R1 status", v, 8'h00);
   endtask

   task automatic t_id();
      logic [7:0] v;
      rd(8'h01, v); chk("R2 id layout", v, 8'hA2);
      rd(8'h01, v); chk("R3 flag cleared", v, 8'hA0);
      chk("R3 irq_n released", {7'd0, irq_n}, 8'h01);
   endtask

   task automatic t_drive();
      wr(8'h07, 8'h00); wr(8'h03, 8'h0F); wr(8'h05, 8'h05);
      chk("R4 pin_oe", pin_oe, 8'h0F);
      chk("R4 pin_out", pin_out, 8'h05);
      chk("R6 pull only inputs", pull_en, 8'hF0);
   endtask

   task automatic t_hiz();
      wr(8'h07, 8'h03);
      chk("R5 hiz override", pin_oe, 8'h0C);
   endtask

   task automatic t_pull();
      wr(8'h0D, 8'h30); wr(8'h0B, 8'h1F);
      chk("R6 pull_up", pull_up, 8'h30);
      chk("R6 pull_en", pull_en, 8'h10);
   endtask

   task automatic t_input();
      logic [7:0] v;
      pin_in = 8'h5A;
      tick(1);
      rd(8'h0F, v); chk("R7 one edge old", v, 8'hFF);
      rd(8'h0F, v); chk("R7 two edges new", v, 8'h5A);
      tick(2);
      rd(8'h13, v); chk("R8 masked no status", v, 8'h00);
      chk("R8 masked irq_n", {7'd0, irq_n}, 8'h01);
      pin_in = 8'hFF; tick(3);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(8'h11, 8'hFB);
      pin_in = 8'hBB; tick(3);
      chk("R10 irq_n asserted", {7'd0, irq_n}, 8'h00);
      rd(8'h13, v); chk("R8 unmasked sets", v, 8'h04);
      rd(8'h13, v); chk("R9 persistent stays", v, 8'h04);
      pin_in = 8'hFF; tick(3);
      rd(8'h13, v); chk("R9 sticky", v, 8'h04);
      rd(8'h13, v); chk("R9 read clears", v, 8'h00);
      chk("R10 irq_n released", {7'd0, irq_n}, 8'h01);
      wr(8'h09, 8'hFB); tick(1);
      rd(8'h13, v); chk("R8 expected level", v, 8'h04);
      wr(8'h09, 8'hFF); tick(1);
      rd(8'h13, v); rd(8'h13, v); chk("R9 cleared after match", v, 8'h00);
   endtask

   task automatic t_readonly();
      logic [7:0] v;
      wr(8'h13, 8'hFF); wr(8'h0F, 8'h00);
      rd(8'h13, v); chk("R12 status not writable", v, 8'h00);
      chk("R12 irq_n", {7'd0, irq_n}, 8'h01);
      rd(8'h0F, v); chk("R12 input not writable", v, 8'hFF);
      rd(8'h02, v); chk("R12 unmapped", v, 8'h00);
   endtask

   task automatic t_soft();
      logic [7:0] v;
      wr(8'h01, 8'h01);
      chk("R11 pin_oe", pin_oe, 8'h00);
      chk("R11 pull_en", pull_en, 8'hFF);
      chk("R11 pull_up", pull_up, 8'hFF);
      chk("R11 irq_n", {7'd0, irq_n}, 8'h00);
      rd(8'h11, v); chk("R11 mask", v, 8'hFF);
      rd(8'h05, v); chk("R11 level", v, 8'h00);
      rd(8'h01, v); chk("R11 id bit0 reads 0", v, 8'hA2);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset(); t_id(); t_drive(); t_hiz(); t_pull();
      t_input(); t_irq(); t_readonly(); t_soft();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule